// File: doc/BRIEF.md
# Session Access State Tracker

This block holds the security state of one secure-memory session. Other logic compares passwords, runs the authentication arithmetic and checks message codes. It reports each outcome to this block as a single-cycle pulse. The block keeps four things: the one password currently active, the one authentication currently active, the communication mode, and a failure count for every password set and every key set.

For the zone addressed by the current command, the caller supplies three things on side inputs: the zone's protection settings (password set, key set, encryption demand). The block then reports whether read and write access are granted right now. It also reports the current mode and which integrity check applies to it. A reset input clears the whole session.

All events are sampled on the rising clock edge. State changes at that edge. The grant outputs follow the new state combinationally from that edge onward. When several events arrive in one cycle, an accepted authentication outcome takes precedence over encryption activation and over a message-code failure.

Top module: `sess_tracker`

## Requirements
- R1: After reset, the mode is standard (`mode` = 2'b00) and `useMac` is 0. No password or authentication is active. A zone with no protection gets read and write grants, and a password-protected zone gets neither.
- R2: A passing read-password attempt for set s makes that password active. A zone protected by set s then gets `rdGrant`=1 and `wrGrant`=0. A zone protected by another set gets no grant.
- R3: A passing write-password attempt for set s grants both read and write to zones protected by set s. A write grant never occurs without a read grant.
- R4: Only one password is active at a time. A new passing attempt replaces the previous one, and a failing attempt leaves no password active.
- R5: Each password set has its own failure counter. A failing accepted attempt adds one to it, up to a ceiling of 4, and a passing attempt clears it. While the counter is at 4, attempts on that set are ignored, including passing ones, and other sets are unaffected.
- R6: A passing authentication with key k enters authenticated mode (`mode` = 2'b01), from any mode. It grants access to zones that require key k and no access to zones that require another key.
- R7: A failing authentication attempt cancels any earlier authentication and returns the mode to standard.
- R8: Each key set has its own failure counter with the same ceiling of 4. While the counter is at 4, authentication attempts with that key are ignored.
- R9: A passing encryption activation moves the mode from authenticated to encrypted (`mode` = 2'b10). In standard mode it has no effect.
- R10: In authenticated or encrypted mode, a failing message-code check raises `macAbort` for exactly one cycle, drops the mode to standard and cancels the authentication. In standard mode, or when the check passes, nothing changes.
- R11: A zone that demands encryption is granted access only while the mode is encrypted.
- R12: `useMac` is 0 in standard mode, where the modification-detection code applies. It is 1 in authenticated and encrypted modes.
- R13: Reset clears all lockouts, so a set or key that had reached its failure ceiling accepts attempts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; clears the whole session |
| pwEvt | input | 1 | Password attempt outcome pulse |
| pwSet | input | 3 | Password set of the attempt |
| pwIsWrite | input | 1 | 1 = write password, 0 = read password |
| pwPass | input | 1 | 1 = password matched |
| authEvt | input | 1 | Authentication outcome pulse |
| authKey | input | 2 | Key set of the authentication |
| authPass | input | 1 | 1 = authentication succeeded |
| encEvt | input | 1 | Encryption activation pulse |
| encPass | input | 1 | 1 = activation succeeded |
| macEvt | input | 1 | Message-code check pulse on an incoming command |
| macPass | input | 1 | 1 = code matched |
| zonePwUse | input | 1 | Addressed zone is password protected |
| zonePwSet | input | 3 | Password set that protects the zone |
| zoneAuthUse | input | 1 | Addressed zone requires authentication |
| zoneKey | input | 2 | Key set assigned to the zone |
| zoneEncReq | input | 1 | Zone demands encrypted mode |
| rdGrant | output | 1 | Read access currently granted |
| wrGrant | output | 1 | Write access currently granted |
| mode | output | 2 | 00 standard, 01 authenticated, 10 encrypted |
| useMac | output | 1 | 1 = message authentication code, 0 = modification-detection code |
| macAbort | output | 1 | One-cycle pulse: command aborted on a code mismatch |

## Verification
The in-line assertions check the relations that must hold on every cycle. These are: counters never pass the ceiling; a write grant always comes with a read grant; an encryption-demanding zone is granted only in encrypted mode; encrypted mode is entered only from authenticated mode; an abort coincides with standard mode; and an attempt on a locked set or key leaves the active state unchanged. Only the directed scenarios can show the sequences behind these relations. Those sequences are: a password being replaced or cancelled; a counter being cleared by a success before it reaches the ceiling; a lockout that survives a correct password and ends at reset; and the mode ladder being climbed and then torn down by a code mismatch.

// File: rtl/sess_pkg.sv
package sess_pkg;
  localparam int SESS_PW_SETS  = 8;
  localparam int SESS_KEY_SETS = 4;
  localparam int SESS_PW_W     = $clog2(SESS_PW_SETS);
  localparam int SESS_KEY_W    = $clog2(SESS_KEY_SETS);

  typedef enum logic [1:0] {
    MODE_STD  = 2'b00,
    MODE_AUTH = 2'b01,
    MODE_ENC  = 2'b10
  } sessMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  pwHit;   // accepted password attempt
    logic                  pwOk;
    logic                  pwWr;
    logic [SESS_PW_W-1:0]  pwIdx;
    logic                  authHit; // accepted authentication attempt
    logic                  authOk;
    logic [SESS_KEY_W-1:0] keyIdx;
    logic                  encUp;   // climb to encrypted mode
    logic                  macDrop; // fall back to standard mode
  } sessStrobe_t;
endpackage

// File: rtl/sess_ctrl.sv
module sess_ctrl
  import sess_pkg::*;
#(
  parameter int PW_SETS  = SESS_PW_SETS,
  parameter int KEY_SETS = SESS_KEY_SETS,
  localparam int PW_W    = $clog2(PW_SETS),
  localparam int KEY_W   = $clog2(KEY_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwEvt,
  input  logic [PW_W-1:0]     pwSet,
  input  logic                pwIsWrite,
  input  logic                pwPass,
  input  logic                authEvt,
  input  logic [KEY_W-1:0]    authKey,
  input  logic                authPass,
  input  logic                encEvt,
  input  logic                encPass,
  input  logic                macEvt,
  input  logic                macPass,
  input  logic [PW_SETS-1:0]  pwLockVec,
  input  logic [KEY_SETS-1:0] keyLockVec,
  input  sessMode_e           modeNow,
  output sessStrobe_t         stb
);
  logic authTake;

  // a locked set or key swallows the attempt
  assign authTake = authEvt && !keyLockVec[authKey];

  always_comb begin
    stb         = '0;
    stb.pwHit   = pwEvt && !pwLockVec[pwSet];
    stb.pwOk    = pwPass;
    stb.pwWr    = pwIsWrite;
    stb.pwIdx   = pwSet;
    stb.authHit = authTake;
    stb.authOk  = authPass;
    stb.keyIdx  = authKey;
    // an authentication outcome in the same cycle overrides these
    stb.encUp   = encEvt && encPass && (modeNow == MODE_AUTH) && !authTake;
    stb.macDrop = macEvt && !macPass && (modeNow != MODE_STD) && !authTake;
  end

  // R9: no climb request leaves standard mode
  p_no_enc_from_std_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == MODE_STD) |-> !stb.encUp);

  // R10: standard mode never produces an abort strobe
  p_no_drop_in_std_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == MODE_STD) |-> !stb.macDrop);
endmodule

// File: rtl/sess_dp.sv
module sess_dp
  import sess_pkg::*;
#(
  parameter int PW_SETS    = SESS_PW_SETS,
  parameter int KEY_SETS   = SESS_KEY_SETS,
  parameter int FAIL_LIMIT = 4,
  localparam int PW_W      = $clog2(PW_SETS),
  localparam int KEY_W     = $clog2(KEY_SETS),
  localparam int CNT_W     = $clog2(FAIL_LIMIT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sessStrobe_t         stb,
  input  logic                zonePwUse,
  input  logic [PW_W-1:0]     zonePwSet,
  input  logic                zoneAuthUse,
  input  logic [KEY_W-1:0]    zoneKey,
  input  logic                zoneEncReq,
  output logic [PW_SETS-1:0]  pwLockVec,
  output logic [KEY_SETS-1:0] keyLockVec,
  output sessMode_e           modeNow,
  output logic                pwActive,
  output logic                authActive,
  output logic                rdGrant,
  output logic                wrGrant,
  output logic                macAbort
);
  localparam logic [CNT_W-1:0] CEIL = CNT_W'(FAIL_LIMIT);

  logic [PW_W-1:0]  pwActSet;
  logic             pwActWr;
  logic [KEY_W-1:0] authActKey;

  // active password: one at a time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwActive <= 1'b0;
      pwActSet <= '0;
      pwActWr  <= 1'b0;
    end else if (stb.pwHit) begin
      pwActive <= stb.pwOk;
      pwActSet <= stb.pwIdx;
      pwActWr  <= stb.pwWr;
    end
  end

  // authentication and mode ladder
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      authActive <= 1'b0;
      authActKey <= '0;
      modeNow    <= MODE_STD;
      macAbort   <= 1'b0;
    end else begin
      macAbort <= stb.macDrop;
      if (stb.authHit) begin
        authActive <= stb.authOk;
        authActKey <= stb.keyIdx;
        modeNow    <= stb.authOk ? MODE_AUTH : MODE_STD;
      end else if (stb.macDrop) begin
        authActive <= 1'b0;
        modeNow    <= MODE_STD;
      end else if (stb.encUp) begin
        modeNow    <= MODE_ENC;
      end
    end
  end

  // per-set and per-key failure counters
  for (genvar gi = 0; gi < PW_SETS; gi++) begin : g_pwCnt
    logic [CNT_W-1:0] failCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          failCnt <= '0;
      else if (stb.pwHit && stb.pwIdx == PW_W'(gi)) begin
        if (stb.pwOk)                                     failCnt <= '0;
        else if (failCnt != CEIL)                         failCnt <= failCnt + 1'b1;
      end
    end
    assign pwLockVec[gi] = (failCnt == CEIL);

    p_pw_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
      (failCnt == CEIL) |=> (failCnt == CEIL) || (failCnt == '0));
  end

  for (genvar gk = 0; gk < KEY_SETS; gk++) begin : g_keyCnt
    logic [CNT_W-1:0] failCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                            failCnt <= '0;
      else if (stb.authHit && stb.keyIdx == KEY_W'(gk)) begin
        if (stb.authOk)                                     failCnt <= '0;
        else if (failCnt != CEIL)                           failCnt <= failCnt + 1'b1;
      end
    end
    assign keyLockVec[gk] = (failCnt == CEIL);

    p_key_cnt_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
      (failCnt == CEIL) |=> (failCnt == CEIL) || (failCnt == '0));
  end

  // access decision for the addressed zone
  logic pwMatch, rdPwOk, wrPwOk, keyOk, encOk;
  always_comb begin
    pwMatch = pwActive && (pwActSet == zonePwSet);
    rdPwOk  = !zonePwUse || pwMatch;
    wrPwOk  = !zonePwUse || (pwMatch && pwActWr);
    keyOk   = !zoneAuthUse || (authActive && authActKey == zoneKey);
    encOk   = !zoneEncReq || (modeNow == MODE_ENC);
    rdGrant = rdPwOk && keyOk && encOk;
    wrGrant = wrPwOk && keyOk && encOk;
  end

  // R3: a write grant implies a read grant
  p_wr_gives_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrGrant |-> rdGrant);

  // R11: encryption-demanding zone only served in encrypted mode
  p_enc_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdGrant && zoneEncReq) |-> (modeNow == MODE_ENC));

  // R9: encrypted mode entered only from authenticated mode
  p_enc_from_auth_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow != MODE_ENC) |=> (modeNow != MODE_ENC) || ($past(modeNow) == MODE_AUTH));

  // R10: an abort pulse is seen together with standard mode
  p_abort_std_r10: assert property (@(posedge clk) disable iff (!rstN)
    macAbort |-> (modeNow == MODE_STD && !authActive));

  // R6: authentication and non-standard mode go together
  p_auth_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    authActive == (modeNow != MODE_STD));
endmodule

// File: rtl/sess_tracker.sv
module sess_tracker
  import sess_pkg::*;
#(
  parameter int PW_SETS    = SESS_PW_SETS,
  parameter int KEY_SETS   = SESS_KEY_SETS,
  parameter int FAIL_LIMIT = 4,
  localparam int PW_W      = $clog2(PW_SETS),
  localparam int KEY_W     = $clog2(KEY_SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwEvt,
  input  logic [PW_W-1:0]  pwSet,
  input  logic             pwIsWrite,
  input  logic             pwPass,
  input  logic             authEvt,
  input  logic [KEY_W-1:0] authKey,
  input  logic             authPass,
  input  logic             encEvt,
  input  logic             encPass,
  input  logic             macEvt,
  input  logic             macPass,
  input  logic             zonePwUse,
  input  logic [PW_W-1:0]  zonePwSet,
  input  logic             zoneAuthUse,
  input  logic [KEY_W-1:0] zoneKey,
  input  logic             zoneEncReq,
  output logic             rdGrant,
  output logic             wrGrant,
  output logic [1:0]       mode,
  output logic             useMac,
  output logic             macAbort
);
  sessStrobe_t         stb;
  sessMode_e           modeNow;
  logic [PW_SETS-1:0]  pwLockVec;
  logic [KEY_SETS-1:0] keyLockVec;
  logic                pwActive, authActive;

  sess_ctrl #(.PW_SETS(PW_SETS), .KEY_SETS(KEY_SETS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pwEvt(pwEvt), .pwSet(pwSet), .pwIsWrite(pwIsWrite), .pwPass(pwPass),
    .authEvt(authEvt), .authKey(authKey), .authPass(authPass),
    .encEvt(encEvt), .encPass(encPass), .macEvt(macEvt), .macPass(macPass),
    .pwLockVec(pwLockVec), .keyLockVec(keyLockVec), .modeNow(modeNow),
    .stb(stb)
  );

  sess_dp #(.PW_SETS(PW_SETS), .KEY_SETS(KEY_SETS), .FAIL_LIMIT(FAIL_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .zonePwUse(zonePwUse), .zonePwSet(zonePwSet), .zoneAuthUse(zoneAuthUse),
    .zoneKey(zoneKey), .zoneEncReq(zoneEncReq),
    .pwLockVec(pwLockVec), .keyLockVec(keyLockVec), .modeNow(modeNow),
    .pwActive(pwActive), .authActive(authActive),
    .rdGrant(rdGrant), .wrGrant(wrGrant), .macAbort(macAbort)
  );

  assign mode   = modeNow;
  assign useMac = (modeNow != MODE_STD);

  // R5: an attempt on a locked password set changes nothing
  p_pw_lock_ignore_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pwEvt && pwLockVec[pwSet]) |=> $stable(pwActive));

  // R8: an attempt with a locked key changes nothing
  p_key_lock_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (authEvt && keyLockVec[authKey] && !macEvt) |=> $stable(authActive));
endmodule

// File: tb/sim_sess_tracker.sv
`timescale 1ns/1ps
module sim_sess_tracker;
  logic clk = 1'b0, rstN = 1'b0;
  logic pwEvt = 0, pwIsWrite = 0, pwPass = 0;
  logic [2:0] pwSet = 0;
  logic authEvt = 0, authPass = 0;
  logic [1:0] authKey = 0;
  logic encEvt = 0, encPass = 0, macEvt = 0, macPass = 0;
  logic zonePwUse = 0, zoneAuthUse = 0, zoneEncReq = 0;
  logic [2:0] zonePwSet = 0;
  logic [1:0] zoneKey = 0;
  logic rdGrant, wrGrant, useMac, macAbort;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sess_tracker u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setZone(logic pu, logic [2:0] ps, logic au, logic [1:0] k, logic er);
    zonePwUse = pu; zonePwSet = ps; zoneAuthUse = au; zoneKey = k; zoneEncReq = er;
    #0.1;
  endtask

  task automatic doPw(logic [2:0] s, logic w, logic p);
    @(negedge clk); pwEvt = 1; pwSet = s; pwIsWrite = w; pwPass = p;
    @(negedge clk); pwEvt = 0;
  endtask

  task automatic doAuth(logic [1:0] k, logic p);
    @(negedge clk); authEvt = 1; authKey = k; authPass = p;
    @(negedge clk); authEvt = 0;
  endtask

  task automatic doEnc(logic p);
    @(negedge clk); encEvt = 1; encPass = p;
    @(negedge clk); encEvt = 0;
  endtask

  task automatic doMac(logic p);
    @(negedge clk); macEvt = 1; macPass = p;
    @(negedge clk); macEvt = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    setZone(0, 0, 0, 0, 0);
    chk("R1 mode", mode, 0);
    chk("R1 useMac", useMac, 0);
    chk("R1 open zone rd", rdGrant, 1);
    chk("R1 open zone wr", wrGrant, 1);
    setZone(1, 3, 0, 0, 0);
    chk("R1 pw zone rd", rdGrant, 0);
    chk("R1 pw zone wr", wrGrant, 0);
  endtask

  task automatic t_readPw();
    doPw(3, 0, 1);
    setZone(1, 3, 0, 0, 0);
    chk("R2 rd grant", rdGrant, 1);
    chk("R2 no wr", wrGrant, 0);
    setZone(1, 4, 0, 0, 0);
    chk("R2 other set", rdGrant, 0);
  endtask

  task automatic t_writePw();
    doPw(6, 1, 1);
    setZone(1, 6, 0, 0, 0);
    chk("R3 rd", rdGrant, 1);
    chk("R3 wr", wrGrant, 1);
  endtask

  task automatic t_replace();
    doPw(1, 1, 1);
    setZone(1, 6, 0, 0, 0);
    chk("R4 old replaced", rdGrant, 0);
    setZone(1, 1, 0, 0, 0);
    chk("R4 new active", wrGrant, 1);
    doPw(1, 1, 0);
    chk("R4 fail clears", rdGrant, 0);
  endtask

  task automatic t_pwLock();
    setZone(1, 5, 0, 0, 0);
    for (int i = 0; i < 3; i++) doPw(5, 0, 0);
    doPw(5, 0, 1);
    chk("R5 success clears count", rdGrant, 1);
    for (int i = 0; i < 4; i++) doPw(5, 0, 0);
    doPw(5, 0, 1);
    chk("R5 locked set ignores pass", rdGrant, 0);
    doPw(2, 0, 1);
    setZone(1, 2, 0, 0, 0);
    chk("R5 other set unaffected", rdGrant, 1);
    doPw(5, 1, 0);
    chk("R5 locked fail ignored", rdGrant, 1);
  endtask

  task automatic t_auth();
    setZone(0, 0, 1, 1, 0);
    chk("R6 before auth", rdGrant, 0);
    doAuth(1, 1);
    chk("R6 mode auth", mode, 1);
    chk("R12 useMac auth", useMac, 1);
    chk("R6 key match", rdGrant, 1);
    setZone(0, 0, 1, 2, 0);
    chk("R6 other key", rdGrant, 0);
  endtask

  task automatic t_authFail();
    doAuth(2, 0);
    chk("R7 mode std", mode, 0);
    setZone(0, 0, 1, 1, 0);
    chk("R7 auth cancelled", rdGrant, 0);
  endtask

  task automatic t_keyLock();
    for (int i = 0; i < 4; i++) doAuth(3, 0);
    doAuth(3, 1);
    chk("R8 locked key mode", mode, 0);
    setZone(0, 0, 1, 3, 0);
    chk("R8 locked key no grant", rdGrant, 0);
    doAuth(0, 1);
    chk("R8 other key ok", mode, 1);
  endtask

  task automatic t_enc();
    doReset();
    doEnc(1);
    chk("R9 enc ignored in std", mode, 0);
    doAuth(2, 1);
    setZone(0, 0, 1, 2, 1);
    chk("R11 no grant in auth", rdGrant, 0);
    doEnc(0);
    chk("R9 failed activation", mode, 1);
    doEnc(1);
    chk("R9 mode enc", mode, 2);
    chk("R12 useMac enc", useMac, 1);
    chk("R11 grant in enc", rdGrant, 1);
    doAuth(2, 1);
    chk("R6 re-auth from enc", mode, 1);
  endtask

  task automatic t_mac();
    doMac(1);
    chk("R10 pass no abort", macAbort, 0);
    chk("R10 pass keeps mode", mode, 1);
    doEnc(1);
    @(negedge clk); macEvt = 1; macPass = 0;
    @(negedge clk); macEvt = 0;
    chk("R10 abort pulse", macAbort, 1);
    chk("R10 drop to std", mode, 0);
    chk("R12 useMac std", useMac, 0);
    @(negedge clk);
    chk("R10 abort one cycle", macAbort, 0);
    setZone(0, 0, 1, 2, 0);
    chk("R10 auth lost", rdGrant, 0);
    doMac(0);
    chk("R10 no abort in std", macAbort, 0);
  endtask

  task automatic t_resetClear();
    doReset();
    setZone(1, 5, 0, 0, 0);
    doPw(5, 0, 1);
    chk("R13 pw lock cleared", rdGrant, 1);
    doAuth(3, 1);
    chk("R13 key lock cleared", mode, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_readPw();
    t_writePw();
    t_replace();
    t_pwLock();
    t_auth();
    t_authFail();
    t_keyLock();
    t_enc();
    t_mac();
    t_resetClear();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule